// File: doc/BRIEF.md
# Halt Mode Clock Sequencer

This block steps a chip into and out of its deepest low-power state. When the processor executes its idle instruction it raises a halt request. The sequencer first keeps the system clock running for a flush window, so that the pipeline and any pending bus traffic can drain. The length of that window depends on the input clock divider setting. It then drops the core and peripheral clock enables and powers down the PLL. If the clock comes from a crystal or resonator, it also turns off the on-chip oscillator.

Recovery begins with a falling edge on an active-low wake pin. The edge is captured by an asynchronous latch, so it is seen even though no clock is running. The capture is then synchronized into the oscillator clock domain. The sequencer turns the oscillator back on and waits for a stable indication. It then counts a fixed lock interval. This interval runs in full even when the PLL is bypassed. Only after the interval ends are the clocks re-enabled and normal operation reported. The lock interval is a parameter; its default is 131072 oscillator cycles, and a bench may shorten it.

Top module: `halt_clk_seq`

## Requirements
- R1: While `rst_n` is low, and after reset is released, the block is in the running state (`seq_mode` = 0), with `core_clk_en`, `periph_clk_en` and `osc_en` at 1 and `pll_en` equal to the inverse of `pll_bypass`.
- R2: A `halt_req` sampled high in the running state moves the block to the flush state (`seq_mode` = 1) on that edge. The block stays there with both clock enables high for exactly `FLUSH_CYCLES` cycles when `div_sel` was 0 at acceptance, or exactly twice that when it was 1.
- R3: At the end of the flush the block enters the halted state (`seq_mode` = 2) with both clock enables and `pll_en` at 0. In this state `osc_en` is 0 when `xtal_sel` = 1 (crystal source) and 1 when `xtal_sel` = 0.
- R4: A falling edge on `wake_n` in the halted state, even one held low for less than a clock period, moves the block to the oscillator start state (`seq_mode` = 3) on the third rising clock edge after the fall. In that state `osc_en` = 1 and both clock enables stay 0.
- R5: The block stays in oscillator start until `osc_stable` is sampled high. It then spends exactly `LOCK_CYCLES` cycles in the lock state (`seq_mode` = 4), with clock enables at 0 and `pll_en` equal to the inverse of `pll_bypass`.
- R6: The lock state lasts the same `LOCK_CYCLES` cycles when `pll_bypass` = 1.
- R7: After the lock state the block spends one cycle in the resume state (`seq_mode` = 5) with both clock enables at 1, then returns to the running state.
- R8: A `halt_req` that is high outside the running state is ignored. It neither lengthens the flush nor starts a new halt once the block is back in the running state.
- R9: A falling edge on `wake_n` outside the halted state is ignored. In the running state the block stays running. During the flush the block still halts, and it stays halted until a later wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request from the processor's idle instruction |
| div_sel | input | 1 | Input divider select; 1 doubles the flush window |
| xtal_sel | input | 1 | 1 when the clock source is a crystal or resonator |
| pll_bypass | input | 1 | 1 when the PLL is bypassed |
| wake_n | input | 1 | Active-low wake pin; its falling edge starts recovery |
| osc_stable | input | 1 | Oscillator has settled |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL power enable |
| osc_en | output | 1 | Oscillator enable |
| seq_mode | output | 3 | Sequencer state: 0 run, 1 flush, 2 halted, 3 oscillator start, 4 lock, 5 resume |

## Verification
Full halt and wake rounds run with each divider setting and each clock source. The measured flush length separates the 1x window from the 2x window, and `osc_en` in the halted state separates crystal from external clock handling. Wake is tried with a pulse shorter than one clock and with a long low level, which tells true asynchronous capture apart from plain sampling. Lock rounds with the PLL active and bypassed must give the same lock length. Extra halt requests and wake edges injected while running, flushing and locking must leave the sequence unchanged.

// File: rtl/halt_seq_pkg.sv
// Package: shared state encoding for the halt clock sequencer.
// Assumes: the encoding is visible at the seq_mode port, so values are fixed.
package halt_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_FLUSH     = 3'd1,
        ST_HALTED    = 3'd2,
        ST_OSC_START = 3'd3,
        ST_PLL_LOCK  = 3'd4,
        ST_RESUME    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/wake_capture.sv
// Module: wake_capture
// Captures a falling edge on the wake pin with no clock running, then
// synchronizes the capture into the oscillator clock domain.
// Assumes: arm is high only in the halted state; a fall seen while arm is
// low is dropped, and a low level held through arming does not count.
module wake_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wake_n,
    output logic wake_seen
);

    logic                   edge_hold;
    logic [SYNC_STAGES-1:0] sync_q;

    // Asynchronous edge latch: set by the pin edge, cleared while disarmed.
    always_ff @(negedge wake_n or negedge arm) begin
        if (!arm) begin
            edge_hold <= 1'b0;
        end else begin
            edge_hold <= 1'b1;
        end
    end

    // Synchronizer chain into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], edge_hold};
        end
    end

    assign wake_seen = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/phase_timer.sv
// Module: phase_timer
// Counts the cycles of a timed phase and flags its final cycle.
// Assumes: run falls for at least one cycle between phases and limit >= 1.
module phase_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Count up while the phase runs; restart from zero when it is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == limit - 1'b1);

    // R5: the count never passes the last cycle of the phase.
    p_cnt_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit))
        else $error("phase counter beyond window");

endmodule

// File: rtl/halt_fsm.sv
// Module: halt_fsm
// Sequencing state machine: run, flush, halted, oscillator start, lock
// and resume. Latches the divider select when a halt is accepted.
// Assumes: osc_stable is synchronous to clk; wake_seen comes from a
// synchronizer.
module halt_fsm
    import halt_seq_pkg::*;
#(
    parameter int FLUSH_CYCLES = 32,
    parameter int LOCK_CYCLES  = 131072,
    parameter int CNT_W        = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             div_sel,
    input  logic             wake_seen,
    input  logic             osc_stable,
    input  logic             tmr_done,
    output seq_state_t       state,
    output logic             tmr_run,
    output logic [CNT_W-1:0] tmr_limit
);

    localparam logic [CNT_W-1:0] LIM_FLUSH_1X = CNT_W'(FLUSH_CYCLES);
    localparam logic [CNT_W-1:0] LIM_FLUSH_2X = CNT_W'(2 * FLUSH_CYCLES);
    localparam logic [CNT_W-1:0] LIM_LOCK     = CNT_W'(LOCK_CYCLES);

    seq_state_t state_nx;
    logic       div_q;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:       if (halt_req)   state_nx = ST_FLUSH;
            ST_FLUSH:     if (tmr_done)   state_nx = ST_HALTED;
            ST_HALTED:    if (wake_seen)  state_nx = ST_OSC_START;
            ST_OSC_START: if (osc_stable) state_nx = ST_PLL_LOCK;
            ST_PLL_LOCK:  if (tmr_done)   state_nx = ST_RESUME;
            ST_RESUME:                    state_nx = ST_RUN;
            default:                      state_nx = ST_RUN;
        endcase
    end

    // State register; reset returns to running with clocks on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // Divider select held from halt acceptance through the flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else if (state == ST_RUN && halt_req) begin
            div_q <= div_sel;
        end
    end

    // Timer control: runs in the two timed phases with their own limits.
    always_comb begin
        tmr_run   = (state == ST_FLUSH) || (state == ST_PLL_LOCK);
        tmr_limit = LIM_LOCK;
        if (state == ST_FLUSH) begin
            tmr_limit = div_q ? LIM_FLUSH_2X : LIM_FLUSH_1X;
        end
    end

    // R2/R3: a flush can only continue or end in the halted state.
    p_flush_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> (state == ST_FLUSH || state == ST_HALTED))
        else $error("flush left to wrong state");

    // R4: the halted state is left only for oscillator start.
    p_halt_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED) |=> (state == ST_HALTED || state == ST_OSC_START))
        else $error("halted left to wrong state");

    // R5: no progress past oscillator start without a stable oscillator.
    p_osc_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OSC_START && !osc_stable) |=> (state == ST_OSC_START))
        else $error("left oscillator start early");

    // R7: lock leads only to resume, and resume lasts one cycle into run.
    p_lock_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLL_LOCK) |=> (state == ST_PLL_LOCK || state == ST_RESUME))
        else $error("lock left to wrong state");
    p_resume_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESUME) |=> (state == ST_RUN))
        else $error("resume did not return to run");

    // R9: without a halt request the running state holds, wake or not.
    p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !halt_req) |=> (state == ST_RUN))
        else $error("run left without request");

endmodule

// File: rtl/halt_clk_seq.sv
// Module: halt_clk_seq (top)
// Halt-mode clock sequencer: drives the clock, PLL and oscillator enables
// from the sequencing state and captures the asynchronous wake edge.
// Assumes: clk is the oscillator-domain clock; enables are held high
// during reset.
module halt_clk_seq
    import halt_seq_pkg::*;
#(
    parameter int FLUSH_CYCLES = 32,
    parameter int LOCK_CYCLES  = 131072,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       div_sel,
    input  logic       xtal_sel,
    input  logic       pll_bypass,
    input  logic       wake_n,
    input  logic       osc_stable,
    output logic       core_clk_en,
    output logic       periph_clk_en,
    output logic       pll_en,
    output logic       osc_en,
    output logic [2:0] seq_mode
);

    localparam int FLUSH_MAX = 2 * FLUSH_CYCLES;
    localparam int CNT_MAX   = (LOCK_CYCLES > FLUSH_MAX) ? LOCK_CYCLES : FLUSH_MAX;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    seq_state_t       state;
    logic             wake_seen;
    logic             tmr_run;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    logic             arm;
    logic             clk_on;
    logic             pll_on;

    assign arm = (state == ST_HALTED);

    wake_capture #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .wake_n    (wake_n),
        .wake_seen (wake_seen)
    );

    phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    halt_fsm #(
        .FLUSH_CYCLES(FLUSH_CYCLES),
        .LOCK_CYCLES (LOCK_CYCLES),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .div_sel    (div_sel),
        .wake_seen  (wake_seen),
        .osc_stable (osc_stable),
        .tmr_done   (tmr_done),
        .state      (state),
        .tmr_run    (tmr_run),
        .tmr_limit  (tmr_limit)
    );

    // Enable decode from state; reset forces the running configuration.
    always_comb begin
        clk_on = (state == ST_RUN) || (state == ST_FLUSH) || (state == ST_RESUME);
        pll_on = (state != ST_HALTED) && (state != ST_OSC_START);
        if (!rst_n) begin
            clk_on = 1'b1;
            pll_on = 1'b1;
        end
        core_clk_en   = clk_on;
        periph_clk_en = clk_on;
        pll_en        = pll_on && !pll_bypass;
        osc_en        = !rst_n || (state != ST_HALTED) || !xtal_sel;
        seq_mode      = state;
    end

    // R3: clocks are off for every cycle of the halted state.
    p_halted_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode == 3'd2) |-> (!core_clk_en && !periph_clk_en && !pll_en))
        else $error("clock enabled while halted");

endmodule

// File: tb/halt_clk_seq_tb.sv
// Directed bench for halt_clk_seq: one task per scenario.
module halt_clk_seq_tb;

    localparam int FLUSH_N = 32;
    localparam int LOCK_N  = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic       div_sel = 1'b0;
    logic       xtal_sel = 1'b0;
    logic       pll_bypass = 1'b0;
    logic       wake_n = 1'b1;
    logic       osc_stable = 1'b0;
    logic       core_clk_en, periph_clk_en, pll_en, osc_en;
    logic [2:0] seq_mode;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    halt_clk_seq #(
        .FLUSH_CYCLES(FLUSH_N),
        .LOCK_CYCLES (LOCK_N)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_req      (halt_req),
        .div_sel       (div_sel),
        .xtal_sel      (xtal_sel),
        .pll_bypass    (pll_bypass),
        .wake_n        (wake_n),
        .osc_stable    (osc_stable),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .pll_en        (pll_en),
        .osc_en        (osc_en),
        .seq_mode      (seq_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic short_wake();
        wake_n = 1'b0;
        #1 wake_n = 1'b1;
    endtask

    // R1: reset state and enables.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 clk_en in reset", int'(core_clk_en && periph_clk_en), 1);
        check("R1 osc_en in reset", int'(osc_en), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode after reset", int'(seq_mode), 0);
        check("R1 pll_en after reset", int'(pll_en), 1);
    endtask

    // R9: wake edge while running is ignored.
    task automatic t_wake_in_run();
        @(negedge clk);
        short_wake();
        repeat (6) @(negedge clk);
        check("R9 run ignores wake", int'(seq_mode), 0);
        check("R9 clocks on after wake in run", int'(core_clk_en), 1);
    endtask

    // R2-R8: one full halt and wake round.
    task automatic t_round(input bit dsel, input bit xsel, input bit byp,
                           input bit short_pulse, input int stable_wait,
                           input bit noise);
        int n;
        @(negedge clk);
        div_sel = dsel; xtal_sel = xsel; pll_bypass = byp; halt_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        halt_req = 1'b0;
        check("R2 clocks on in flush", int'(core_clk_en && periph_clk_en), 1);
        n = 0;
        while (seq_mode == 3'd1 && n < 1000) begin
            n++;
            if (noise && n == 3) begin
                short_wake();
                halt_req = 1'b1;
            end else begin
                halt_req = 1'b0;
            end
            @(negedge clk);
        end
        halt_req = 1'b0;
        check(noise ? "R8 flush length with extra request" : "R2 flush length",
              n, dsel ? 2 * FLUSH_N : FLUSH_N);
        check("R3 halted mode", int'(seq_mode), 2);
        check("R3 clocks off", int'(core_clk_en || periph_clk_en || pll_en), 0);
        check("R3 osc_en in halt", int'(osc_en), xsel ? 0 : 1);
        repeat (8) @(negedge clk);
        check(noise ? "R9 wake in flush ignored" : "R3 stays halted", int'(seq_mode), 2);
        if (short_pulse) begin
            short_wake();
        end else begin
            wake_n = 1'b0;
        end
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R4 still halted after two edges", int'(seq_mode), 2);
        @(negedge clk);
        check("R4 osc start on third edge", int'(seq_mode), 3);
        check("R4 osc on, clocks off", int'(osc_en && !core_clk_en), 1);
        wake_n = 1'b1;
        repeat (stable_wait) @(negedge clk);
        check("R5 waits for stable", int'(seq_mode), 3);
        osc_stable = 1'b1;
        @(negedge clk);
        osc_stable = 1'b0;
        check("R5 pll_en in lock", int'(pll_en), byp ? 0 : 1);
        check("R5 clocks off in lock", int'(core_clk_en), 0);
        n = 0;
        while (seq_mode == 3'd4 && n < 100000) begin
            n++;
            halt_req = (noise && n == 10);
            @(negedge clk);
        end
        halt_req = 1'b0;
        check(byp ? "R6 lock length bypassed" : "R5 lock length", n, LOCK_N);
        check("R7 resume mode", int'(seq_mode), 5);
        check("R7 clocks on in resume", int'(core_clk_en && periph_clk_en), 1);
        @(negedge clk);
        check("R7 back to run", int'(seq_mode), 0);
        repeat (5) @(negedge clk);
        check("R8 no stale halt", int'(seq_mode), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_wake_in_run();
        t_round(1'b0, 1'b1, 1'b0, 1'b0, 4, 1'b0);
        t_round(1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        t_round(1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule